// File: doc/BRIEF.md
# Packed 6-bit Index Table Lookup

This block keeps a 512-bit table of sixty-four 8-bit entries. It expands three input vectors of VL bits into four result vectors of 8-bit elements. The three sources are joined into one 3*VL-bit stream of densely packed 6-bit indices. Each index selects one table entry. Every element of every result is written; there is no masking.

After a start, the block emits one result vector per cycle for four cycles. Each vector comes with a valid flag and a 5-bit destination register number. The destination numbers either count upward by one from a base that is a multiple of four, or step by four inside the lower or upper half of a 32-register space.

The table is loaded as a whole word when the block is idle. The number of cycles an operation takes is fixed and never depends on the indices or on the table contents.

Top module: `idx6_lut_expand`

## Requirements
- R1: Table entry k sits at bits [8k+7:8k] of the 512-bit table. A load (`tbl_we` high while idle) replaces the whole table, and the next operation uses the new contents.
- R2: The index stream is {src2, src1, src0}. Index i is taken from bits [6i+5:6i] of that stream, so src0 holds the lowest indices.
- R3: Element e of result r (bits [8e+7:8e] of `out_vec`) equals the table entry selected by index r*(VL/8)+e. All VL/8 elements of each result are written.
- R4: With `strided` low, the destination of result r is 4*`zd` + r.
- R5: With `strided` high, the destination of result r is {`d_hi`, 2'b00, `zd[1:0]`} + 4*r.
- R6: Suppose `start` is sampled while idle at clock edge k. Results r = 0..3 are then presented with `out_valid` high after edges k..k+3, in that order. `busy` is high over those four cycles and low after edge k+4.
- R7: Every operation lasts exactly four busy cycles, whatever the index and table values.
- R8: A table load asserted while busy is ignored. The running operation and the following operations keep the old contents.
- R9: A start asserted while busy is ignored. It neither recaptures the sources nor adds result cycles.
- R10: After reset, `busy` and `out_valid` are low and every table entry is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Load the whole table from `tbl_wdata` |
| tbl_wdata | input | 512 | New table contents, entry k at bits [8k+7:8k] |
| start | input | 1 | Begin an operation on the current sources |
| src0 | input | VL | Lowest part of the index stream |
| src1 | input | VL | Middle part of the index stream |
| src2 | input | VL | Highest part of the index stream |
| strided | input | 1 | Destination pattern: 0 consecutive, 1 strided |
| zd | input | 3 | Destination base field |
| d_hi | input | 1 | Half select for the strided pattern |
| busy | output | 1 | Operation in progress |
| out_valid | output | 1 | `out_vec` and `out_dest` carry a result |
| out_dest | output | 5 | Destination register number of the current result |
| out_vec | output | VL | Current result vector |

## Verification
The assertions assume that a table load and a start never arrive in the same cycle. They also check that the table and the captured index stream stay unchanged for as long as the block is busy. The bench keeps load pulses and start pulses in separate cycles. It places deliberate loads and starts only inside busy windows, or in idle cycles that contain no other request. Sources may change freely while busy, which shows that only the values captured at the start are used.

// File: rtl/idx6_lut_expand.sv
module idx6_lut_expand #(
  parameter int VL = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tbl_we,
  input  logic [511:0]    tbl_wdata,
  input  logic            start,
  input  logic [VL-1:0]   src0,
  input  logic [VL-1:0]   src1,
  input  logic [VL-1:0]   src2,
  input  logic            strided,
  input  logic [2:0]      zd,
  input  logic            d_hi,
  output logic            busy,
  output logic            out_valid,
  output logic [4:0]      out_dest,
  output logic [VL-1:0]   out_vec
);
  localparam int NEL = VL / 8;
  localparam int SW  = 3 * VL;
  localparam int SEG = SW / 4;

  logic [511:0]  tbl;
  logic [SW-1:0] stream;
  logic [1:0]    cnt;
  logic [4:0]    dbase;
  logic          strd_q;
  logic [SEG-1:0] seg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl    <= '0;
      stream <= '0;
      busy   <= 1'b0;
      cnt    <= 2'd0;
      dbase  <= 5'd0;
      strd_q <= 1'b0;
    end else begin
      if (tbl_we && !busy) tbl <= tbl_wdata;
      if (busy) begin
        cnt <= cnt + 2'd1;
        if (cnt == 2'd3) busy <= 1'b0;
      end else if (start) begin
        busy   <= 1'b1;
        cnt    <= 2'd0;
        stream <= {src2, src1, src0};
        strd_q <= strided;
        dbase  <= strided ? {d_hi, 2'b00, zd[1:0]} : {zd, 2'b00};
      end
    end
  end

  assign seg       = stream[int'(cnt) * SEG +: SEG];
  assign out_valid = busy;
  assign out_dest  = dbase + (strd_q ? {1'b0, cnt, 2'b00} : {3'b000, cnt});

  for (genvar e = 0; e < NEL; e++) begin : g_el
    logic [5:0] ix;
    assign ix = seg[e*6 +: 6];
    assign out_vec[e*8 +: 8] = tbl[{ix, 3'b000} +: 8];
  end

  AST_NO_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
    !(tbl_we && start)); // R8
  AST_START_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && out_valid && cnt == 2'd0); // R6
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cnt != 2'd3 |=> busy); // R7
  AST_BEAT_END: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cnt == 2'd3 |=> !busy); // R7
  AST_DEST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cnt != 2'd3 |=> out_dest == $past(out_dest) + (strd_q ? 5'd4 : 5'd1)); // R4 R5
  AST_TBL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(tbl)); // R8
  AST_SRC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(stream)); // R9
endmodule

// File: tb/idx6_lut_expand_bench.sv
module idx6_lut_expand_bench;
  localparam int VL  = 128;
  localparam int NEL = VL / 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, tbl_we, start, strided, d_hi;
  logic [511:0] tbl_wdata;
  logic [VL-1:0] src0, src1, src2;
  logic [2:0] zd;
  logic busy, out_valid;
  logic [4:0] out_dest;
  logic [VL-1:0] out_vec;

  idx6_lut_expand #(.VL(VL)) u_idx6_lut_expand (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_wdata(tbl_wdata),
    .start(start), .src0(src0), .src1(src1), .src2(src2),
    .strided(strided), .zd(zd), .d_hi(d_hi),
    .busy(busy), .out_valid(out_valid), .out_dest(out_dest), .out_vec(out_vec)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [VL-1:0] act, input logic [VL-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [511:0] make_tbl(input int salt);
    logic [511:0] t;
    for (int k = 0; k < 64; k++) t[8*k +: 8] = 8'((k * 29 + 7 + salt * 83) ^ (salt * 11));
    return t;
  endfunction

  function automatic logic [VL-1:0] gen_src(input int seed, input int j);
    logic [VL-1:0] v;
    for (int w = 0; w < VL / 32; w++)
      v[32*w +: 32] = (32'(seed) * 32'h9E3779B1) ^ (32'(w + 1) * 32'h85EBCA6B) ^ (32'(j + 1) * 32'hC2B2AE35);
    return v;
  endfunction

  function automatic logic [VL-1:0] exp_vec(input logic [511:0] t, input logic [VL-1:0] a,
                                            input logic [VL-1:0] b, input logic [VL-1:0] c, input int r);
    logic [3*VL-1:0] s;
    logic [VL-1:0] res;
    int idx;
    s = {c, b, a};
    for (int e = 0; e < NEL; e++) begin
      idx = int'(s[6*(r*NEL + e) +: 6]);
      res[8*e +: 8] = t[8*idx +: 8];
    end
    return res;
  endfunction

  task automatic load_tbl(input logic [511:0] t);
    @(negedge clk);
    tbl_we = 1'b1; tbl_wdata = t;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic run_op(input logic [VL-1:0] a, input logic [VL-1:0] b, input logic [VL-1:0] c,
                        input logic strd, input logic dh, input logic [2:0] z,
                        input logic [511:0] tm, input string dtag,
                        input bit pk_start, input bit pk_we, input logic [511:0] tb);
    logic [4:0] ed;
    @(negedge clk);
    src0 = a; src1 = b; src2 = c; strided = strd; d_hi = dh; zd = z; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int r = 0; r < 4; r++) begin
      ed = strd ? 5'({dh, 2'b00, z[1:0]} + 4 * r) : 5'(4 * z + r);
      chk("R6 valid", VL'(out_valid), VL'(1));
      chk("R7 busy", VL'(busy), VL'(1));
      if (strd) chk("R5 dest", VL'(out_dest), VL'(ed));
      else      chk("R4 dest", VL'(out_dest), VL'(ed));
      chk(dtag, out_vec, exp_vec(tm, a, b, c, r));
      if (pk_start && (r == 1 || r == 3)) begin
        start = 1'b1; src0 = ~a; src1 = ~b; src2 = c ^ {VL{1'b1}}; zd = ~z; strided = ~strd;
      end else start = 1'b0;
      if (pk_we && r == 2) begin tbl_we = 1'b1; tbl_wdata = tb; end
      else tbl_we = 1'b0;
      @(negedge clk);
    end
    start = 1'b0; tbl_we = 1'b0;
    chk("R6 busy done", VL'(busy), VL'(0));
    chk("R9 no extra beat", VL'(out_valid), VL'(0));
  endtask

  localparam logic [31:0] VEC [8] = '{
    {24'h000011, 8'h00}, {24'h0000A7, 8'h05}, {24'h001234, 8'h13},
    {24'h00BEEF, 8'h18}, {24'h00C0DE, 8'h07}, {24'h0F00D5, 8'h1B},
    {24'h777777, 8'h02}, {24'h135790, 8'h16}
  };

  logic [511:0] ta, tbv;

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tbl_we = 1'b0; tbl_wdata = '0; start = 1'b0;
    src0 = '0; src1 = '0; src2 = '0; strided = 1'b0; zd = 3'd0; d_hi = 1'b0;
    ta = make_tbl(1); tbv = make_tbl(5);
    repeat (3) @(negedge clk);
    chk("R10 busy reset", VL'(busy), VL'(0));
    chk("R10 valid reset", VL'(out_valid), VL'(0));
    rst_n = 1'b1;
    run_op(gen_src(9, 0), gen_src(9, 1), gen_src(9, 2), 1'b0, 1'b0, 3'd1, '0, "R10 zero table", 0, 0, '0);

    load_tbl(ta);
    foreach (VEC[i]) begin
      int sd;
      sd = int'(VEC[i][31:8]);
      run_op(gen_src(sd, 0), gen_src(sd, 1), gen_src(sd, 2), VEC[i][4], VEC[i][3], VEC[i][2:0],
             ta, "R2 R3 data", 0, 0, '0);
    end

    run_op({VL{1'b1}}, {VL{1'b1}}, {VL{1'b1}}, 1'b0, 1'b0, 3'd7, ta, "R3 index 63", 0, 0, '0);
    run_op('0, '0, '0, 1'b1, 1'b1, 3'd3, ta, "R1 entry 0", 0, 0, '0);
    run_op(gen_src(44, 0), gen_src(44, 1), gen_src(44, 2), 1'b0, 1'b1, 3'd2, ta, "R9 data", 1, 0, '0);
    run_op(gen_src(45, 0), gen_src(45, 1), gen_src(45, 2), 1'b1, 1'b0, 3'd6, ta, "R8 data during", 0, 1, tbv);
    run_op(gen_src(46, 0), gen_src(46, 1), gen_src(46, 2), 1'b0, 1'b0, 3'd4, ta, "R8 data after", 0, 0, '0);
    load_tbl(tbv);
    run_op(gen_src(47, 0), gen_src(47, 1), gen_src(47, 2), 1'b1, 1'b0, 3'd5, tbv, "R1 reload", 0, 0, '0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule